// File: doc/BRIEF.md
# Event Routing Fabric

The block routes single-bit hardware events from a bus of 63 generator lines to eight output channels. Each channel selects one generator line, or none. It then shapes that line according to a per-channel timing path. On the two clocked paths, a programmable edge detector turns level changes into one-clock pulses. The resynchronising variant adds two synchroniser flops ahead of the detector. The asynchronous path hands the raw level to the output combinationally. A fourth path code silences the channel completely.

All configuration passes through one 32-bit write word that carries a channel index. A write therefore changes only the addressed channel's settings. The same word carries a self-clearing software trigger, which fires a one-clock pulse on the addressed channel. A read word returns the stored settings of the channel written most recently. Reset is asynchronous and active low, and the block releases it synchronously inside.

Top module: `evt_route_fabric`

## Requirements
- R1: After reset, every channel holds generator 0, path 0 and edge mode 0, every bit of `chan_evt` is 0, and `cfg_rdata` reads 0.
- R2: A write with `cfg_we` high updates only the channel named in `cfg_wdata[2:0]`. `cfg_rdata` returns that channel's settings: index in bits 2:0, generator in 21:16, path in 25:24, edge mode in 27:26. Every other bit reads 0, even when it was written as 1.
- R3: Generator code 0 connects no line, so the selected level is constant 0. Code n (1 to 63) selects `gen_in[n-1]`.
- R4: On the synchronous path (code 0), edge mode 1 reacts to rises only, 2 to falls only, 3 to both, and 0 to nothing. A qualifying change applied before clock edge k makes `chan_evt` high during the cycle after edge k+1.
- R5: The resynchronising path (code 1) has the same four edge modes, and its pulse appears exactly two cycles later than on the synchronous path.
- R6: On the asynchronous path (code 2), `chan_evt` follows the selected level combinationally in the same cycle, and a software trigger has no effect on it.
- R7: Path code 3 holds the channel output at 0, whatever the inputs or software triggers.
- R8: A write with bit 8 set, whose path field is 0 or 1, raises the addressed channel's output for one clock in the cycle after the write edge, whatever its edge mode. Bit 8 always reads back as 0.
- R9: A software trigger and a detected hardware edge that land on the same clock edge on the same channel merge into a single one-clock pulse.
- R10: Each detected edge yields an output pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: index, software trigger, generator, path, edge mode |
| cfg_rdata | output | 32 | Settings of the channel most recently written |
| gen_in | input | 63 | Event generator lines |
| chan_evt | output | 8 | One event output per channel |

## Verification
The generator lines get single rises, single falls, level holds and toggles on every cycle. These are applied under each edge mode, which separates rise-only, fall-only, both-edge and disabled detection, and shows that pulses come out one clock wide. The same rise goes through the synchronous and resynchronising paths, so the two extra cycles of latency show up as a fixed offset. A wrong stage tap would shift it. Generator codes 0, 1 and 63 test the ends of the selection range. A write that sets every bit, and a software trigger that coincides with a hardware edge, test reserved-bit masking and pulse merging. Changes to one channel while the others are active show that their settings do not interfere.

// File: rtl/evr_pkg.sv
package evr_pkg;

  localparam int EVR_WORD_W  = 32;
  localparam int EVR_IDX_W   = 3;
  localparam int EVR_NUM_CH  = 1 << EVR_IDX_W;
  localparam int EVR_GEN_W   = 6;
  localparam int EVR_NUM_GEN = (1 << EVR_GEN_W) - 1;

  // field positions inside the configuration word
  localparam int F_IDX_LSB  = 0;
  localparam int F_SW_BIT   = 8;
  localparam int F_GEN_LSB  = 16;
  localparam int F_PATH_LSB = 24;
  localparam int F_EDGE_LSB = 26;

  typedef enum logic [1:0] {
    PATH_SYNC   = 2'd0,
    PATH_RESYNC = 2'd1,
    PATH_ASYNC  = 2'd2,
    PATH_OFF    = 2'd3
  } evr_path_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } evr_edge_e;

  typedef struct packed {
    logic [EVR_GEN_W-1:0] gen;
    evr_path_e            path;
    evr_edge_e            edg;
  } evr_cfg_t;

  function automatic logic evr_edge_hit(evr_edge_e mode, logic cur, logic prev);
    logic hit;
    unique case (mode)
      EDGE_RISE: hit = cur & ~prev;
      EDGE_FALL: hit = ~cur & prev;
      EDGE_BOTH: hit = cur ^ prev;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic evr_is_clocked(evr_path_e p);
    return (p == PATH_SYNC) || (p == PATH_RESYNC);
  endfunction

endpackage

// File: rtl/evr_cfg_bank.sv
module evr_cfg_bank
  import evr_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [EVR_WORD_W-1:0]           wr_word,
  output logic [EVR_WORD_W-1:0]           rd_word,
  output evr_cfg_t [EVR_NUM_CH-1:0]       cfg_all,
  output logic [EVR_NUM_CH-1:0]           sw_hit
);

  evr_cfg_t [EVR_NUM_CH-1:0] cfg_q, cfg_d;
  logic [EVR_IDX_W-1:0]      last_q, last_d;
  logic [EVR_IDX_W-1:0]      wr_idx;
  evr_cfg_t                  wr_cfg;

  assign wr_idx      = wr_word[F_IDX_LSB +: EVR_IDX_W];
  assign wr_cfg.gen  = wr_word[F_GEN_LSB +: EVR_GEN_W];
  assign wr_cfg.path = evr_path_e'(wr_word[F_PATH_LSB +: 2]);
  assign wr_cfg.edg  = evr_edge_e'(wr_word[F_EDGE_LSB +: 2]);

  // next-state
  always_comb begin
    cfg_d  = cfg_q;
    last_d = last_q;
    if (wr_en) begin
      cfg_d[wr_idx] = wr_cfg;
      last_d        = wr_idx;
    end
  end

  // state, with explicit write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      last_q <= '0;
    end else if (wr_en) begin
      cfg_q  <= cfg_d;
      last_q <= last_d;
    end
  end

  // read-back of the last addressed channel, unused bits forced low
  always_comb begin
    rd_word                           = '0;
    rd_word[F_IDX_LSB +: EVR_IDX_W]   = last_q;
    rd_word[F_GEN_LSB +: EVR_GEN_W]   = cfg_q[last_q].gen;
    rd_word[F_PATH_LSB +: 2]          = cfg_q[last_q].path;
    rd_word[F_EDGE_LSB +: 2]          = cfg_q[last_q].edg;
  end

  // software trigger decode, gated by the path carried in the same word
  for (genvar c = 0; c < EVR_NUM_CH; c++) begin : g_sw
    assign sw_hit[c] = wr_en && wr_word[F_SW_BIT] &&
                       (wr_idx == EVR_IDX_W'(c)) && evr_is_clocked(wr_cfg.path);
  end

  assign cfg_all = cfg_q;

endmodule

// File: rtl/evr_gen_mux.sv
module evr_gen_mux
  import evr_pkg::*;
(
  input  logic [EVR_NUM_GEN-1:0] gen_in,
  input  logic [EVR_GEN_W-1:0]   sel,
  output logic                   lvl
);

  // slot 0 is the unconnected generator
  logic [EVR_NUM_GEN:0] padded;

  assign padded = {gen_in, 1'b0};
  assign lvl    = padded[sel];

endmodule

// File: rtl/evr_chan_core.sv
module evr_chan_core
  import evr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl,
  input  evr_cfg_t cfg,
  input  logic     sw_hit,
  output logic     evt
);

  localparam int CHAIN = SYNC_STAGES + 2;

  logic [CHAIN-1:0] stage_q, stage_d;
  logic             cur, prev;
  logic             hw_hit;
  logic             pulse_q, pulse_d;

  // stage 0 is the registered input; stages 1..SYNC_STAGES form the synchroniser
  assign stage_d = {stage_q[CHAIN-2:0], lvl};

  always_comb begin
    unique case (cfg.path)
      PATH_SYNC: begin
        cur  = stage_q[0];
        prev = stage_q[1];
      end
      PATH_RESYNC: begin
        cur  = stage_q[SYNC_STAGES];
        prev = stage_q[SYNC_STAGES+1];
      end
      default: begin
        cur  = 1'b0;
        prev = 1'b0;
      end
    endcase
  end

  assign hw_hit  = evr_is_clocked(cfg.path) && evr_edge_hit(cfg.edg, cur, prev);
  assign pulse_d = hw_hit | sw_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    unique case (cfg.path)
      PATH_ASYNC: evt = lvl;
      PATH_OFF:   evt = 1'b0;
      default:    evt = pulse_q;
    endcase
  end

endmodule

// File: rtl/evt_route_fabric.sv
module evt_route_fabric
  import evr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [EVR_WORD_W-1:0]   cfg_wdata,
  output logic [EVR_WORD_W-1:0]   cfg_rdata,
  input  logic [EVR_NUM_GEN-1:0]  gen_in,
  output logic [EVR_NUM_CH-1:0]   chan_evt
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  evr_cfg_t [EVR_NUM_CH-1:0] cfg_all;
  logic [EVR_NUM_CH-1:0]     sw_hit;

  evr_cfg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_word (cfg_wdata),
    .rd_word (cfg_rdata),
    .cfg_all (cfg_all),
    .sw_hit  (sw_hit)
  );

  for (genvar c = 0; c < EVR_NUM_CH; c++) begin : g_ch
    logic sel_lvl;

    evr_gen_mux u_mux (
      .gen_in (gen_in),
      .sel    (cfg_all[c].gen),
      .lvl    (sel_lvl)
    );

    evr_chan_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .lvl    (sel_lvl),
      .cfg    (cfg_all[c]),
      .sw_hit (sw_hit[c]),
      .evt    (chan_evt[c])
    );
  end

endmodule

// File: rtl/evr_checker.sv
module evr_checker
  import evr_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic [EVR_WORD_W-1:0]     cfg_wdata,
  input logic [EVR_WORD_W-1:0]     cfg_rdata,
  input logic [EVR_NUM_CH-1:0]     chan_evt,
  input evr_cfg_t [EVR_NUM_CH-1:0] cfg_all
);

  localparam logic [EVR_WORD_W-1:0] LIVE_MASK =
      (EVR_WORD_W'((1 << EVR_IDX_W) - 1) << F_IDX_LSB) |
      (EVR_WORD_W'((1 << EVR_GEN_W) - 1) << F_GEN_LSB) |
      (EVR_WORD_W'(3) << F_PATH_LSB) |
      (EVR_WORD_W'(3) << F_EDGE_LSB);

  AST_RD_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~LIVE_MASK) == '0);  // R2

  AST_SW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[F_SW_BIT] && (cfg_wdata[F_PATH_LSB +: 2] < 2'd2)
    |=> chan_evt[$past(cfg_wdata[F_IDX_LSB +: EVR_IDX_W])]);  // R8

  for (genvar c = 0; c < EVR_NUM_CH; c++) begin : g_chk
    AST_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && (cfg_wdata[F_IDX_LSB +: EVR_IDX_W] != EVR_IDX_W'(c))
      |=> $stable(cfg_all[c]));  // R2

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_all[c].path == PATH_OFF |-> !chan_evt[c]);  // R7

    AST_ASYNC_NO_GEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_all[c].path == PATH_ASYNC) && (cfg_all[c].gen == '0) |-> !chan_evt[c]);  // R6

    AST_EDGE_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_all[c].path == PATH_SYNC) && ($past(cfg_all[c].path) == PATH_SYNC) &&
      ($past(cfg_all[c].edg) == EDGE_NONE) &&
      !$past(cfg_we && cfg_wdata[F_SW_BIT] &&
             (cfg_wdata[F_IDX_LSB +: EVR_IDX_W] == EVR_IDX_W'(c)))
      |-> !chan_evt[c]);  // R4
  end

endmodule

bind evt_route_fabric evr_checker u_evr_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .chan_evt  (chan_evt),
  .cfg_all   (cfg_all)
);

// File: tb/tb_evt_route_fabric.sv
module tb_evt_route_fabric;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [62:0] gen_in;
  logic [7:0]  chan_evt;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  evt_route_fabric dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .gen_in(gen_in), .chan_evt(chan_evt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int m_gen [8];
  int m_path[8];
  int m_edge[8];
  bit m_pulse[8];
  bit hist [8][$];
  int m_last;

  function automatic bit ref_lvl(int g);
    if (g == 0) return 1'b0;
    return gen_in[g-1];
  endfunction

  function automatic bit ref_edge(int mode, bit cur, bit prev);
    case (mode)
      1: return cur && !prev;
      2: return !cur && prev;
      3: return cur != prev;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) begin
        m_gen[c] = 0; m_path[c] = 0; m_edge[c] = 0; m_pulse[c] = 0;
        hist[c].delete();
        for (int k = 0; k < 4; k++) hist[c].push_back(1'b0);
      end
      m_last = 0;
    end else begin
      for (int c = 0; c < 8; c++) begin
        bit hw, sw, cur, prev;
        cur = 0; prev = 0;
        if (m_path[c] == 0) begin cur = hist[c][0]; prev = hist[c][1]; end
        if (m_path[c] == 1) begin cur = hist[c][2]; prev = hist[c][3]; end
        hw = (m_path[c] < 2) && ref_edge(m_edge[c], cur, prev);
        sw = cfg_we && cfg_wdata[8] && (int'(cfg_wdata[2:0]) == c) && (cfg_wdata[25:24] < 2);
        m_pulse[c] = hw || sw;
        hist[c].push_front(ref_lvl(m_gen[c]));
        void'(hist[c].pop_back());
      end
      if (cfg_we) begin
        int ix;
        ix = int'(cfg_wdata[2:0]);
        m_gen[ix]  = int'(cfg_wdata[21:16]);
        m_path[ix] = int'(cfg_wdata[25:24]);
        m_edge[ix] = int'(cfg_wdata[27:26]);
        m_last     = ix;
      end
    end
  end

  function automatic logic [7:0] ref_evt();
    logic [7:0] v;
    for (int c = 0; c < 8; c++) begin
      if (m_path[c] == 2)      v[c] = ref_lvl(m_gen[c]);
      else if (m_path[c] == 3) v[c] = 1'b0;
      else                     v[c] = m_pulse[c];
    end
    return v;
  endfunction

  function automatic logic [31:0] ref_rd();
    return (32'(m_edge[m_last]) << 26) | (32'(m_path[m_last]) << 24) |
           (32'(m_gen[m_last]) << 16) | 32'(m_last);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the reference on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, {24'd0, chan_evt}, {24'd0, ref_evt()});
      check("R2", cfg_rdata, ref_rd());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic wr_raw(logic [31:0] w);
    tick();
    cfg_we = 1'b1; cfg_wdata = w;
    tick();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic wr(int ch, int g, int p, int e, bit sw);
    wr_raw({4'd0, 2'(e), 2'(p), 2'd0, 6'(g), 7'd0, sw, 5'd0, 3'(ch)});
  endtask

  task automatic setg(int b, bit v);
    tick();
    gen_in[b] = v;
  endtask

  task automatic expect_evt(string req, int ch, bit v);
    check(req, {31'd0, chan_evt[ch]}, {31'd0, v});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; gen_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check("R1", cfg_rdata, 32'd0);
    check("R1", {24'd0, chan_evt}, 32'd0);

    // R4 synchronous rising, generator 5 -> gen_in[4]
    cur_req = "R4";
    wr(0, 5, 0, 1, 0);
    setg(4, 1);
    tick(); expect_evt("R4", 0, 0);
    tick(); expect_evt("R4", 0, 1);
    tick(); expect_evt("R10", 0, 0);
    setg(4, 0);
    tick(); expect_evt("R4", 0, 0);
    tick(); expect_evt("R4", 0, 0);

    // R4 falling and both on channel 1, generator 10
    wr(1, 10, 0, 2, 0);
    setg(9, 1); idle(3);
    setg(9, 0);
    tick(); expect_evt("R4", 1, 0);
    tick(); expect_evt("R4", 1, 1);
    wr(1, 10, 0, 3, 0);
    setg(9, 1);
    tick(); tick(); expect_evt("R4", 1, 1);
    tick(); expect_evt("R10", 1, 0);
    cur_req = "R10";
    setg(9, 0); setg(9, 1); setg(9, 0); idle(4);
    cur_req = "R4";
    wr(1, 10, 0, 0, 0);
    setg(9, 1); setg(9, 0);
    tick(); expect_evt("R4", 1, 0);
    tick(); expect_evt("R4", 1, 0);

    // R5 resynchronising path, generator 63 -> gen_in[62]
    cur_req = "R5";
    wr(2, 63, 1, 1, 0);
    setg(62, 1);
    tick(); expect_evt("R5", 2, 0);
    tick(); expect_evt("R5", 2, 0);
    tick(); expect_evt("R5", 2, 0);
    tick(); expect_evt("R5", 2, 1);
    tick(); expect_evt("R5", 2, 0);
    wr(2, 63, 1, 2, 0);
    setg(62, 0);
    idle(3); expect_evt("R5", 2, 0);
    tick(); expect_evt("R5", 2, 1);
    idle(2);

    // R3 generator 0 never produces an edge
    cur_req = "R3";
    wr(6, 0, 0, 3, 0);
    setg(0, 1); setg(20, 1); setg(0, 0); setg(20, 0);
    tick(); expect_evt("R3", 6, 0);
    idle(3);

    // R6 asynchronous pass-through, generator 1 -> gen_in[0]
    cur_req = "R6";
    wr(3, 1, 2, 0, 0);
    setg(0, 1); #1; expect_evt("R6", 3, 1);
    tick(); expect_evt("R6", 3, 1);
    setg(0, 0); #1; expect_evt("R6", 3, 0);
    wr(3, 1, 2, 3, 1);
    expect_evt("R6", 3, 0);
    tick(); expect_evt("R6", 3, 0);

    // R7 path 3 with every bit of the word set (index 5)
    cur_req = "R7";
    wr_raw(32'hFFFF_FFFD);
    check("R2", cfg_rdata, 32'h0F3F_0005);
    expect_evt("R7", 5, 0);
    setg(62, 1); setg(62, 0); idle(3);
    expect_evt("R7", 5, 0);

    // R2 reconfiguring one channel leaves another intact
    cur_req = "R2";
    wr(7, 33, 1, 3, 0);
    check("R2", cfg_rdata, 32'h0D21_0007);
    setg(4, 1);
    tick(); tick(); expect_evt("R2", 0, 1);
    idle(2);

    // R8 software trigger with edge mode 0
    cur_req = "R8";
    wr(1, 10, 0, 0, 1);
    expect_evt("R8", 1, 1);
    check("R8", cfg_rdata, 32'h000A_0001);
    tick(); expect_evt("R8", 1, 0);

    // R9 software trigger merging with a hardware rise
    cur_req = "R9";
    setg(4, 0); idle(3);
    setg(4, 1);
    wr(0, 5, 0, 1, 1);
    expect_evt("R9", 0, 1);
    tick(); expect_evt("R9", 0, 0);
    tick(); expect_evt("R9", 0, 0);
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule